// File: doc/BRIEF.md
# GPIO Port with Falling-Edge Interrupt

This block is one general purpose I/O port of up to eight pins, programmed through a small synchronous register bus. Each pin has a direction bit and a data bit. A pin whose direction bit is set is an output and drives its data bit. A pin whose direction bit is clear is an input. On an input pin, a data bit of 1 turns the pad's internal pull-up on. The pad levels are brought into the clock domain through a two-flop synchronizer. A falling edge on any input pin marks the port's single interrupt as pending.

The pending bit stays set until software pulses a clear strobe. If a new edge arrives in the same cycle as the clear, the pending bit stays set. The port's interrupt request is the pending bit gated by a port enable input. A read of the direction offset returns the synchronized pin levels, because the direction bits themselves cannot be read back. A parameter narrows the port, for example to four pins. The unimplemented upper bits then read as zero and ignore writes.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every implemented pin is an input (pad_oe all 0), the data register holds all ones, so pad_pu is 1 on every implemented pin, and irq is 0.
- R2: A write to offset 0 loads the direction register. Bit n set to 1 makes pin n an output (pad_oe[n]=1). pad_out[n] always shows data bit n.
- R3: A read of offset 0 returns the synchronized pad levels, with bit n being pin n, and never the direction bits. A pad change is visible to a read issued two clock cycles later.
- R4: A write to offset 1 loads the data register, with bit n driving pin n. A read of offset 1 returns the stored data.
- R5: pad_pu[n] is 1 exactly when pin n is an input (direction 0) and its data bit is 1.
- R6: A 1-to-0 change on the pad of an input pin sets the pending bit on the third rising clock edge after the change. A 0-to-1 change sets nothing.
- R7: A pin whose direction bit is 1 never sets the pending bit, whatever its pad does.
- R8: The pending bit holds until irq_clr is sampled high. If a falling edge is detected in the same cycle as irq_clr, the pending bit stays set.
- R9: irq is the pending bit AND irq_en. Dropping irq_en masks irq but keeps the pending bit, so irq returns when irq_en is raised again.
- R10: With PORT_W below 8, rdata bits at and above PORT_W read 0, and write data in those bits is ignored.
- R11: Read data appears on rdata one cycle after the read access. Offsets 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset: 0 direction / pin levels, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | PORT_W | Raw pad input levels |
| pad_oe | output | PORT_W | Per-pin output enable |
| pad_out | output | PORT_W | Per-pin output value |
| pad_pu | output | PORT_W | Per-pin pull-up enable |
| irq_en | input | 1 | Port interrupt enable |
| irq_clr | input | 1 | Pending-bit clear strobe |
| irq | output | 1 | Port interrupt request |

## Verification
The bench counts cycles on a falling pad edge and expects irq on the third edge. A synchronizer one stage short or long moves irq by a cycle and fails the check. It drives pad falls on output pins and rising pad changes on inputs, where a detector that ignores direction or polarity would raise a false request. It lands a new edge in the exact cycle of the clear strobe; a design that gives the clear priority would lose that interrupt. It also reads offset 0 after loading a direction pattern different from the pad levels, and drives a four-pin instance with full-width writes, where a design that returns the direction bits or leaks upper bits would fail the readback.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_LVL_DIR = 2'd0,
        ADR_DATA    = 2'd1,
        ADR_RSV2    = 2'd2,
        ADR_RSV3    = 2'd3
    } gpio_adr_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] lvl_now,
    output logic [W-1:0] lvl_prev
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
        logic [W-1:0] older;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = raw_in;
        st_d.stable = st_q.meta;
        st_d.older  = st_q.stable;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_now  = st_q.stable;
    assign lvl_prev = st_q.older;

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
    import gpio_edge_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [PORT_W-1:0] pin_lvl,
    output logic [PORT_W-1:0] dir,
    output logic [PORT_W-1:0] data,
    output logic [BUS_W-1:0]  rdata
);

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] data;
        logic [BUS_W-1:0]  rdata;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sel && wr) begin
            case (gpio_adr_e'(addr))
                ADR_LVL_DIR: r_d.dir  = wdata[PORT_W-1:0];
                ADR_DATA:    r_d.data = wdata[PORT_W-1:0];
                default:     ;
            endcase
        end
        if (sel && !wr) begin
            r_d.rdata = '0;
            case (gpio_adr_e'(addr))
                ADR_LVL_DIR: r_d.rdata[PORT_W-1:0] = pin_lvl;
                ADR_DATA:    r_d.rdata[PORT_W-1:0] = r_q.data;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.dir   <= '0;
            r_q.data  <= '1;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dir   = r_q.dir;
    assign data  = r_q.data;
    assign rdata = r_q.rdata;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] lvl_now,
    input  logic [PORT_W-1:0] lvl_prev,
    input  logic [PORT_W-1:0] dir,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              pend,
    output logic              irq
);

    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t s_d, s_q;
    logic [PORT_W-1:0] fall;

    always_comb begin
        fall       = lvl_prev & ~lvl_now & ~dir;
        s_d        = s_q;
        s_d.pend   = (s_q.pend && !irq_clr) || (|fall);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend = s_q.pend;
    assign irq  = s_q.pend && irq_en;

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic              irq
);

    logic [PORT_W-1:0] lvl_now, lvl_prev;
    logic [PORT_W-1:0] dir_q, data_q;
    logic              pend;

    gpio_edge_sync #(.W(PORT_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev)
    );

    gpio_edge_regs #(.PORT_W(PORT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .pin_lvl (lvl_now),
        .dir     (dir_q),
        .data    (data_q),
        .rdata   (bus_rdata)
    );

    gpio_edge_irq #(.PORT_W(PORT_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_now  (lvl_now),
        .lvl_prev (lvl_prev),
        .dir      (dir_q),
        .irq_en   (irq_en),
        .irq_clr  (irq_clr),
        .pend     (pend),
        .irq      (irq)
    );

    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        assign pad_oe[p]  = dir_q[p];
        assign pad_out[p] = data_q[p];
        assign pad_pu[p]  = !dir_q[p] && data_q[p];
    end

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [7:0]        bus_rdata,
    input logic [PORT_W-1:0] lvl_now,
    input logic [PORT_W-1:0] lvl_prev,
    input logic [PORT_W-1:0] dir_q,
    input logic              pend,
    input logic              irq_en,
    input logic              irq_clr,
    input logic              irq
);

    // R3
    pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd0) |=> bus_rdata[PORT_W-1:0] == $past(lvl_now));

    // R6
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(|(lvl_prev & ~lvl_now & ~dir_q)));

    // R7
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && (&dir_q)) |=> !pend);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !irq_clr) |=> pend);

    // R9
    mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    if (PORT_W < 8) begin : g_narrow
        // R10
        upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[7:PORT_W] == '0);
    end

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.PORT_W(PORT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .lvl_now   (lvl_now),
    .lvl_prev  (lvl_prev),
    .dir_q     (dir_q),
    .pend      (pend),
    .irq_en    (irq_en),
    .irq_clr   (irq_clr),
    .irq       (irq)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] pad_in = 8'hFF;
    logic       irq_en = 1'b0, irq_clr = 1'b0;

    logic [7:0] rd_w, rd_n;
    logic [7:0] oe_w, out_w, pu_w;
    logic [3:0] oe_n, out_n, pu_n;
    logic       irq_w, irq_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_edge_port #(.PORT_W(8)) i_gpio_edge_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_w),
        .pad_in(pad_in), .pad_oe(oe_w), .pad_out(out_w), .pad_pu(pu_w),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq_w)
    );

    gpio_edge_port #(.PORT_W(4)) i_narrow (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_n),
        .pad_in(pad_in[3:0]), .pad_oe(oe_n), .pad_out(out_n), .pad_pu(pu_n),
        .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq_n)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clr_pulse();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 oe", oe_w, 8'h00);
        check("R1 pu", pu_w, 8'hFF);
        check("R1 irq", {7'd0, irq_w}, 8'h00);
        rd_reg(2'd1);
        check("R1 data", rd_w, 8'hFF);
        check("R10 data narrow", rd_n, 8'h0F);
        check("R1 pu narrow", {4'd0, pu_n}, 8'h0F);
    endtask

    task automatic t_regs();
        wr_reg(2'd0, 8'h3C);
        check("R2 oe", oe_w, 8'h3C);
        check("R5 pu dir", pu_w, 8'hC3);
        wr_reg(2'd1, 8'hA5);
        check("R2 out", out_w, 8'hA5);
        check("R5 pu data", pu_w, 8'h81);
        rd_reg(2'd1);
        check("R4 read data", rd_w, 8'hA5);
        check("R10 read narrow", rd_n, 8'h05);
        check("R2 oe narrow", {4'd0, oe_n}, 8'h0C);
        check("R5 pu narrow", {4'd0, pu_n}, 8'h01);
    endtask

    task automatic t_pins();
        pad_in = 8'h96;
        wait_n(2);
        rd_reg(2'd0);
        check("R3 pin levels", rd_w, 8'h96);
        check("R10 pin narrow", rd_n, 8'h06);
        rd_reg(2'd2);
        check("R11 offset2", rd_w, 8'h00);
        rd_reg(2'd3);
        check("R11 offset3", rd_w, 8'h00);
        pad_in = 8'hFF;
        wait_n(3);
    endtask

    task automatic t_edge();
        wr_reg(2'd0, 8'h0F);
        irq_en = 1'b1;
        wait_n(3);
        clr_pulse();
        check("R8 clear", {7'd0, irq_w}, 8'h00);
        pad_in = 8'h7F;
        @(negedge clk);
        check("R6 edge+1", {7'd0, irq_w}, 8'h00);
        @(negedge clk);
        check("R6 edge+2", {7'd0, irq_w}, 8'h00);
        @(negedge clk);
        check("R6 edge+3", {7'd0, irq_w}, 8'h01);
        check("R7 narrow outputs", {7'd0, irq_n}, 8'h00);
        pad_in = 8'hFF;
        wait_n(3);
        clr_pulse();
        wait_n(4);
        check("R6 rise ignored", {7'd0, irq_w}, 8'h00);
    endtask

    task automatic t_out();
        pad_in = 8'hF0;
        wait_n(5);
        check("R7 output pins", {7'd0, irq_w}, 8'h00);
        check("R7 output narrow", {7'd0, irq_n}, 8'h00);
        pad_in = 8'hFF;
        wait_n(3);
    endtask

    task automatic t_sticky();
        pad_in = 8'hBF;
        wait_n(3);
        check("R6 pin6", {7'd0, irq_w}, 8'h01);
        wait_n(10);
        check("R8 held", {7'd0, irq_w}, 8'h01);
        clr_pulse();
        check("R8 cleared", {7'd0, irq_w}, 8'h00);
        pad_in = 8'hFF;
        wait_n(3);
        clr_pulse();
        pad_in = 8'hEF;
        wait_n(2);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R8 edge beats clear", {7'd0, irq_w}, 8'h01);
        clr_pulse();
        check("R8 clear after", {7'd0, irq_w}, 8'h00);
        pad_in = 8'hFF;
        wait_n(3);
        clr_pulse();
    endtask

    task automatic t_mask();
        irq_en = 1'b0;
        pad_in = 8'hDF;
        wait_n(4);
        check("R9 masked", {7'd0, irq_w}, 8'h00);
        irq_en = 1'b1;
        @(negedge clk);
        check("R9 pending kept", {7'd0, irq_w}, 8'h01);
        pad_in = 8'hFF;
        wait_n(3);
        clr_pulse();
    endtask

    task automatic t_narrow();
        wr_reg(2'd0, 8'h00);
        pad_in = 8'hFE;
        wait_n(3);
        check("R6 narrow edge", {7'd0, irq_n}, 8'h01);
        wr_reg(2'd1, 8'hF0);
        rd_reg(2'd1);
        check("R10 upper write ignored", rd_n, 8'h00);
        check("R4 wide data", rd_w, 8'hF0);
        check("R5 pu narrow zero", {4'd0, pu_n}, 8'h00);
        check("R5 pu wide", pu_w, 8'hF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_pins();
        t_edge();
        t_out();
        t_sticky();
        t_mask();
        t_narrow();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule